// File: doc/BRIEF.md
# Serial-In Latched Output Driver Logic

This block is the digital core of a cascadable serial-to-parallel driver for display segments and similar loads. A host shifts bits in on a serial data pin, qualified by a slow serial clock. Every rising edge of that clock moves the whole chain one place towards a serial output pin. A further device can hang off that pin to extend the chain. A strobe level copies the chain into a holding bank. The bank stays transparent for as long as strobe is high, and it freezes when strobe is low. A blanking level forces every parallel enable off without touching what the bank holds. When blanking drops, the outputs come back to the held pattern.

All four control and data inputs are plain, level-style pins, so there is no valid/ready exchange and no back-pressure. The host paces itself by the serial clock. The pins are sampled in a fast system clock domain through a synchronizer chain. Serial clock edges are detected in that same domain, and the holding bank is a strobe-qualified register rather than an inferred latch. The width of the chain is a parameter with a minimum of 2. Output index 0 is the first shift stage, and index N-1 is the last stage, which also feeds the serial output.

Top module: `sild_driver`

## Requirements
- R1: While rst_n is low at a clk edge, the shift stages and holding bank clear, so drv_en reads all zeros and sdo reads 0 after that edge.
- R2: Each rising edge of sclk loads sdi into stage 0 and moves stage k-1 into stage k for every k from 1 to N-1.
- R3: sdo always shows the last stage (index N-1). After N+j shifts, sdo therefore carries the bit that was shifted in j+1-th.
- R4: While strobe is high, the holding bank follows the shift stages continuously, so each shift made with strobe high is reflected on drv_en.
- R5: While strobe is low, the holding bank keeps its value, and drv_en does not change when new bits are shifted.
- R6: While blank is high, every drv_en bit is 0 (off), whatever the bank holds.
- R7: Blanking leaves the holding bank unchanged. When blank returns low, drv_en again shows the bank, including any load made by strobe during blanking.
- R8: A falling edge of sclk, or sclk held at one level, shifts nothing, and changes on sdi between rising edges have no effect.
- R9: The default width is 10 stages. Bit position i of drv_en is driven by shift stage i, so the first of N bits shifted in appears on drv_en[N-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all other inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial shift clock; rising edge shifts |
| sdi | input | 1 | Serial data in |
| strobe | input | 1 | High: holding bank transparent; low: hold |
| blank | input | 1 | High: force all enables off |
| drv_en | output | N | Parallel output enables, 1 = on |
| sdo | output | 1 | Serial data out (last stage), for cascading |

## Verification
The assertions assume that sclk stays at each level for several system clock cycles, so that one rising edge is seen as exactly one shift. They also assume that sdi is already settled when sclk rises. The stimulus sets sdi three system cycles before raising sclk and holds each sclk level for six cycles. Strobe and blank change only while sclk is still, and every check is sampled after the synchronizer and register stages have settled. This keeps each expected value independent of how the asynchronous pins are sampled.

// File: rtl/sild_pkg.sv
package sild_pkg;
  parameter int unsigned SILD_DEF_WIDTH = 10;
  parameter int unsigned SILD_DEF_SYNC  = 2;

  // Order of the bits in the synchronizer bundle
  typedef enum int unsigned {
    PIN_SCLK   = 0,
    PIN_SDI    = 1,
    PIN_STROBE = 2,
    PIN_BLANK  = 3
  } pin_idx_e;

  localparam int unsigned PIN_COUNT = 4;
endpackage

// File: rtl/sild_sync.sv
module sild_sync #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/sild_shift.sv
module sild_shift #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  output logic [N-1:0] stages,
  output logic         sout
);
  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    chain_q <= '0;
    else if (step) chain_q <= {chain_q[N-2:0], din};
  end

  assign stages = chain_q;
  assign sout   = chain_q[N-1];
endmodule

// File: rtl/sild_hold.sv
module sild_hold #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      bank_q <= '0;
    else if (open_i) bank_q <= d;
  end

  assign q = bank_q;
endmodule

// File: rtl/sild_gate.sv
module sild_gate #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         force_off,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] out_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         out_q <= '0;
    else if (force_off) out_q <= '0;
    else                out_q <= d;
  end

  assign q = out_q;
endmodule

// File: rtl/sild_driver.sv
module sild_driver
  import sild_pkg::*;
#(
  parameter int unsigned N          = SILD_DEF_WIDTH,
  parameter int unsigned SYNC_DEPTH = SILD_DEF_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         strobe,
  input  logic         blank,
  output logic [N-1:0] drv_en,
  output logic         sdo
);
  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_q;
  logic                 sclk_prev_q;
  logic                 shift_step;
  logic                 sdi_q;
  logic                 strobe_q;
  logic                 blank_q;
  logic [N-1:0]         stage_q;
  logic [N-1:0]         latch_q;

  always_comb begin
    pins_raw             = '0;
    pins_raw[PIN_SCLK]   = sclk;
    pins_raw[PIN_SDI]    = sdi;
    pins_raw[PIN_STROBE] = strobe;
    pins_raw[PIN_BLANK]  = blank;
  end

  sild_sync #(.DEPTH(SYNC_DEPTH), .W(PIN_COUNT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_q)
  );

  assign sdi_q    = pins_q[PIN_SDI];
  assign strobe_q = pins_q[PIN_STROBE];
  assign blank_q  = pins_q[PIN_BLANK];

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= pins_q[PIN_SCLK];
  end

  assign shift_step = pins_q[PIN_SCLK] & ~sclk_prev_q;

  sild_shift #(.N(N)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (shift_step),
    .din   (sdi_q),
    .stages(stage_q),
    .sout  (sdo)
  );

  sild_hold #(.N(N)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .open_i(strobe_q),
    .d     (stage_q),
    .q     (latch_q)
  );

  sild_gate #(.N(N)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_off(blank_q),
    .d        (latch_q),
    .q        (drv_en)
  );
endmodule

// File: rtl/sild_driver_chk.sv
module sild_driver_chk #(
  parameter int unsigned N = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step,
  input logic         strobe_q,
  input logic         blank_q,
  input logic [N-1:0] stages,
  input logic [N-1:0] latched,
  input logic [N-1:0] drv_en,
  input logic         sdo
);
  // R1: reset clears outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (drv_en == '0 && sdo == 1'b0));

  // R2: a detected rising edge moves every stage up one place
  a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> stages[N-1:1] == $past(stages[N-2:0]));

  // R8: without an edge the chain stays put
  a_r8_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(stages));

  // R3: serial out takes the bit previously one stage below
  a_r3_sdo_follows: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> sdo == $past(stages[N-2]));

  // R4: bank transparent while strobe is high
  a_r4_bank_follows: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> latched == $past(stages));

  // R5: bank frozen while strobe is low
  a_r5_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |=> $stable(latched));

  // R6: blanking forces outputs off
  a_r6_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |=> drv_en == '0);

  // R7: unblanked outputs track the bank
  a_r7_unblank_shows: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_q |=> drv_en == $past(latched));
endmodule

bind sild_driver sild_driver_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .step    (shift_step),
  .strobe_q(strobe_q),
  .blank_q (blank_q),
  .stages  (stage_q),
  .latched (latch_q),
  .drv_en  (drv_en),
  .sdo     (sdo)
);

// File: tb/sild_driver_test.sv
module sild_driver_test;
  localparam int unsigned N = 10;

  typedef struct {
    string        tag;
    logic [N-1:0] drv;
    logic         so;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0;
  logic         sdi = 1'b0;
  logic         strobe = 1'b0;
  logic         blank = 1'b0;
  logic [N-1:0] drv_en;
  logic         sdo;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t sb_q[$];
  logic [N-1:0] m_shift = '0;
  logic [N-1:0] m_bank  = '0;
  logic [2*N-1:0] first_two;

  always #2.5 clk = ~clk;

  sild_driver #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
    .strobe(strobe), .blank(blank), .drv_en(drv_en), .sdo(sdo)
  );

  // monitor: pops expectations and compares at a falling edge
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      @(negedge clk);
      begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (drv_en !== e.drv || sdo !== e.so) begin
          n_fail++;
          $display("FAIL %s: drv_en=%b sdo=%b expected drv_en=%b sdo=%b",
                   e.tag, drv_en, sdo, e.drv, e.so);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.tag  = tag;
    e.drv  = blank ? '0 : m_bank;
    e.so   = m_shift[N-1];
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic set_strobe(input logic v);
    strobe = v;
    if (v) m_bank = m_shift;
    idle(6);
  endtask

  task automatic push_bit(input logic b);
    sdi = b;
    idle(3);
    sclk = 1'b1;
    m_shift = {m_shift[N-2:0], b};
    if (strobe) m_bank = m_shift;
    idle(6);
    sclk = 1'b0;
    idle(6);
  endtask

  task automatic push_word(input logic [N-1:0] w, input string tag);
    for (int i = N - 1; i >= 0; i--) begin
      push_bit(w[i]);
      expect_now(tag);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sclk = 1'b0; sdi = 1'b0; strobe = 1'b0; blank = 1'b0;
    idle(4);
    m_shift = '0; m_bank = '0;
    rst_n = 1'b1;
    idle(4);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    expect_now("R1 reset state");

    // R2 R3 R5: shift with strobe low, outputs hold at zero
    push_word(10'b1011001110, "R5 hold while shifting");
    expect_now("R2 chain after word");
    // R4 R9: strobe loads, first bit lands on drv_en[N-1]
    set_strobe(1'b1);
    expect_now("R9 bit order after load");
    if (drv_en !== 10'b1011001110) begin
      n_fail++;
      $display("FAIL R9: drv_en=%b expected %b", drv_en, 10'b1011001110);
    end
    n_checks++;
    set_strobe(1'b0);

    // R3: second word pushes first word out through sdo (cascade)
    first_two = '0;
    for (int i = N - 1; i >= 0; i--) begin
      logic b;
      b = (i % 3 == 0);
      push_bit(b);
      expect_now("R3 cascade sdo");
    end

    // R4: transparent while strobe high, each shift shows
    set_strobe(1'b1);
    push_word(10'b0110100101, "R4 transparent shift");
    set_strobe(1'b0);

    // R8: sdi toggled while sclk held high does nothing
    sdi = ~m_shift[0];
    idle(3);
    sclk = 1'b1;
    m_shift = {m_shift[N-2:0], sdi};
    idle(6);
    expect_now("R2 single rising edge");
    for (int k = 0; k < 6; k++) begin
      sdi = ~sdi;
      idle(4);
    end
    expect_now("R8 sclk high held");
    sclk = 1'b0;
    idle(8);
    expect_now("R8 falling edge no shift");

    // R6 R7: blanking
    blank = 1'b1;
    idle(6);
    expect_now("R6 blank forces off");
    push_word(10'b1111100000, "R6 blank during shift");
    set_strobe(1'b1);
    expect_now("R7 load while blanked");
    set_strobe(1'b0);
    blank = 1'b0;
    idle(6);
    expect_now("R7 restore after blank");
    blank = 1'b1;
    idle(6);
    expect_now("R6 blank again");
    blank = 1'b0;
    idle(6);
    expect_now("R7 bank unchanged by blank");

    // all ones then R1 reset mid-operation
    set_strobe(1'b1);
    push_word('1, "R4 all ones");
    set_strobe(1'b0);
    do_reset();
    expect_now("R1 reset mid run");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule